// File: doc/BRIEF.md
# Low-Power Timer Counter Core

A register-programmed up/down counter for a low-power timer subsystem. Software reaches it through a small bus. One register enables the timer and issues the start command, and one register picks the counting source. A ceiling register holds the wrap point. A compare register holds a stored value. A status register reports that ceiling and compare updates have completed, and a clear register drops those status bits. The current count is read back through a read-only register.

The core counts in one of two modes. In event mode it adds one on each selected edge of input 1: rising, falling or both. In encoder mode an external quadrature decoder supplies a per-cycle step strobe and a direction bit. A ceiling or compare write is accepted only while the timer is enabled. It lands after a fixed delay, which models a synchronization delay, and it raises a sticky completion flag at the same time. Counting runs only after a start command has been issued to an already-enabled timer.

The bus is single-cycle. A write is taken on the rising clock edge where `sel_i` and `we_i` are both high. The read data is a combinational decode of `addr_i`. The address map is:
- 0: control. Bit 0 is enable. Bit 1 is start on write. A read returns {running, enable} in bits [1:0].
- 1: configuration.
- 2: ceiling.
- 3: compare.
- 4: status. Bit 0 is ceiling done. Bit 1 is compare done.
- 5: clear. This address is write-only.
- 6: count. This address is read-only.
- Unmapped addresses read 0.

Top module: `lpt_core`

## Requirements
- R1: A control write with bit 0 set enables the timer, and bit 1 issues start. Counting begins only when start is written while enable is already set. A single write that sets both bits leaves the timer enabled but not running. A control read returns bit 0 = enabled and bit 1 = running.
- R2: A control write with bit 0 clear disables the timer and stops counting. The count holds its value while stopped.
- R3: Ceiling and compare writes made while the timer is disabled are ignored. The stored value and the completion flag both stay unchanged.
- R4: After an accepted ceiling or compare write, the new value and the completion flag appear 3 cycles after the write edge. Status bit 0 is ceiling done and bit 1 is compare done. Until then the old value and a clear flag read back.
- R5: The completion flags are sticky. A write to the clear register with bit 0 set clears ceiling done, and with bit 1 set clears compare done. A zero bit leaves its flag unchanged.
- R6: Configuration bit 0 selects encoder mode (1) or event mode (0). Bits [2:1] select the active edge: 0 is rising, 1 is falling, 2 or 3 is both edges. Configuration writes are ignored while enabled.
- R7: In event mode a running timer adds one on each selected edge of input 1. The encoder step and direction inputs have no effect.
- R8: In encoder mode a running timer counts up on each cycle where step is 1 and direction is 1, and counts down on each cycle where step is 1 and direction is 0. Input 1 has no effect.
- R9: Counting up from a value at or above the ceiling wraps to 0. Counting down from 0 wraps to the ceiling.
- R10: After reset the ceiling is 0xFFFF. The compare value, count, configuration, control and flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Bus access select |
| we_i | input | 1 | Write strobe (with sel_i) |
| addr_i | input | 3 | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for addr_i |
| in1_i | input | 1 | Event input used in event mode |
| enc_step_i | input | 1 | Per-cycle step strobe from quadrature decoder |
| enc_up_i | input | 1 | Step direction from decoder, 1 = up |

## Verification
A run state that is wrong shows within one cycle. The control read reports it directly, and the count register moves or fails to move on the next edge or step. A misplaced stage in the completion delay shifts when the ceiling or compare read-back changes and when its status bit rises. The bench reads every cycle of that window, so the wrong cycle is visible. A wrap or edge-selection error shows as a wrong count on the first read after a short run of edges or steps whose result is computed in advance.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CFG  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CEIL = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CMP  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_CLR  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd6;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'd0,
    EDGE_FALL  = 2'd1,
    EDGE_ANY   = 2'd2,
    EDGE_ANY_B = 2'd3
  } edge_sel_e;

  typedef struct packed {
    edge_sel_e edge_sel;  // [2:1]
    logic      enc_mode;  // [0]
  } cfg_t;
endpackage

// File: rtl/lpt_edge_sel.sv
module lpt_edge_sel
  import lpt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      in_i,
  input  edge_sel_e sel_i,
  output logic      ev_o
);
  logic in_q;
  logic rise_w, fall_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_q <= 1'b0;
    else         in_q <= in_i;
  end

  assign rise_w = in_i & ~in_q;
  assign fall_w = ~in_i & in_q;

  always_comb begin
    case (sel_i)
      EDGE_RISE: ev_o = rise_w;
      EDGE_FALL: ev_o = fall_w;
      default:   ev_o = rise_w | fall_w;
    endcase
  end
endmodule

// File: rtl/lpt_dly_reg.sv
module lpt_dly_reg #(
  parameter int unsigned W       = 16,
  parameter int unsigned LAT     = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o,
  output logic         done_o
);
  logic [LAT-1:0] pipe_q, pipe_d;
  logic [W-1:0]   pend_q, val_q;
  logic           done_q;
  logic           land_w;

  always_comb begin
    pipe_d[0] = wr_i;
    for (int i = 1; i < LAT; i++) pipe_d[i] = pipe_q[i-1];
  end

  assign land_w = pipe_q[LAT-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      pend_q <= RST_VAL;
      val_q  <= RST_VAL;
      done_q <= 1'b0;
    end else begin
      pipe_q <= pipe_d;
      if (wr_i)   pend_q <= wdata_i;
      if (land_w) val_q  <= pend_q;
      // set beats clear in the same cycle
      done_q <= land_w | (done_q & ~clr_i);
    end
  end

  assign q_o    = val_q;
  assign done_o = done_q;
endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic [W-1:0] ceil_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (run_i) begin
      if (inc_i)      cnt_q <= (cnt_q >= ceil_i) ? '0 : cnt_q + 1'b1;
      else if (dec_i) cnt_q <= (cnt_q == '0) ? ceil_i : cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lpt_core.sv
module lpt_core
  import lpt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned WR_LAT = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sel_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [CNT_W-1:0]      wdata_i,
  output logic [CNT_W-1:0]      rdata_o,
  input  logic                  in1_i,
  input  logic                  enc_step_i,
  input  logic                  enc_up_i
);
  localparam logic [CNT_W-1:0] CEIL_RST = {CNT_W{1'b1}};

  logic wr_w, wr_ctrl_w, wr_cfg_w, wr_ceil_w, wr_cmp_w, wr_clr_w;
  logic en_q, run_q;
  cfg_t cfg_q;
  logic clr_ceil_w, clr_cmp_w;
  logic [CNT_W-1:0] ceil_w, cmp_w, cnt_w;
  logic ceil_ok_w, cmp_ok_w;
  logic ev1_w, inc_w, dec_w;

  assign wr_w      = sel_i & we_i;
  assign wr_ctrl_w = wr_w && (addr_i == ADR_CTRL);
  assign wr_cfg_w  = wr_w && (addr_i == ADR_CFG);
  assign wr_ceil_w = wr_w && (addr_i == ADR_CEIL);
  assign wr_cmp_w  = wr_w && (addr_i == ADR_CMP);
  assign wr_clr_w  = wr_w && (addr_i == ADR_CLR);

  // start counts only if enable was already set before this write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
    end else if (wr_ctrl_w) begin
      en_q  <= wdata_i[0];
      run_q <= wdata_i[0] & (run_q | (wdata_i[1] & en_q));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cfg_q <= '0;
    else if (wr_cfg_w && !en_q) cfg_q <= cfg_t'(wdata_i[2:0]);
  end

  assign clr_ceil_w = wr_clr_w & wdata_i[0];
  assign clr_cmp_w  = wr_clr_w & wdata_i[1];

  lpt_dly_reg #(.W(CNT_W), .LAT(WR_LAT), .RST_VAL(CEIL_RST)) u_ceil (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_ceil_w & en_q), .wdata_i(wdata_i),
    .clr_i(clr_ceil_w), .q_o(ceil_w), .done_o(ceil_ok_w)
  );

  lpt_dly_reg #(.W(CNT_W), .LAT(WR_LAT), .RST_VAL('0)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_cmp_w & en_q), .wdata_i(wdata_i),
    .clr_i(clr_cmp_w), .q_o(cmp_w), .done_o(cmp_ok_w)
  );

  lpt_edge_sel u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(in1_i), .sel_i(cfg_q.edge_sel), .ev_o(ev1_w)
  );

  assign inc_w = cfg_q.enc_mode ? (enc_step_i & enc_up_i) : ev1_w;
  assign dec_w = cfg_q.enc_mode & enc_step_i & ~enc_up_i;

  lpt_counter #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .inc_i(inc_w), .dec_i(dec_w),
    .ceil_i(ceil_w), .cnt_o(cnt_w)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_CTRL: rdata_o[1:0] = {run_q, en_q};
      ADR_CFG:  rdata_o[2:0] = cfg_q;
      ADR_CEIL: rdata_o      = ceil_w;
      ADR_CMP:  rdata_o      = cmp_w;
      ADR_STAT: rdata_o[1:0] = {cmp_ok_w, ceil_ok_w};
      ADR_CNT:  rdata_o      = cnt_w;
      default:  rdata_o      = '0;
    endcase
  end
endmodule

// File: rtl/lpt_core_chk.sv
module lpt_core_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_ctrl_i,
  input logic             en_i,
  input logic             run_i,
  input logic [2:0]       cfg_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] ceil_i,
  input logic             ceil_ok_i,
  input logic             clr_ceil_i,
  input logic             inc_i,
  input logic             dec_i
);
  AST_RUN_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> en_i);  // R1
  AST_START_NEEDS_PRIOR_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && !en_i && !run_i) |=> !run_i);  // R1
  AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_i));  // R2
  AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> $stable(cfg_i));  // R6
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ceil_ok_i && !clr_ceil_i) |=> ceil_ok_i);  // R5
  AST_WRAP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && inc_i && cnt_i >= ceil_i) |=> cnt_i == '0);  // R9
  AST_WRAP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && dec_i && !inc_i && cnt_i == '0) |=> cnt_i == $past(ceil_i));  // R9
endmodule

bind lpt_core lpt_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_ctrl_i(wr_ctrl_w), .en_i(en_q), .run_i(run_q),
  .cfg_i(cfg_q), .cnt_i(cnt_w), .ceil_i(ceil_w), .ceil_ok_i(ceil_ok_w),
  .clr_ceil_i(clr_ceil_w), .inc_i(inc_w), .dec_i(dec_w)
);

// File: tb/sim_lpt_core.sv
`timescale 1ns/1ps
module sim_lpt_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        in1 = 1'b0, step = 1'b0, up = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0]  a;
    logic [15:0] e;
    string       tag;
  } item_t;
  item_t q[$];
  event chk_ev;

  localparam logic [2:0] A_CTRL = 3'd0, A_CFG = 3'd1, A_CEIL = 3'd2, A_CMP = 3'd3,
                         A_STAT = 3'd4, A_CLR = 3'd5, A_CNT = 3'd6;

  lpt_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .in1_i(in1), .enc_step_i(step), .enc_up_i(up)
  );

  always #2 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pops expected items and compares with the read bus
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() != 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (rdata !== it.e) begin
          n_fail++;
          $display("FAIL %s: addr %0d got %h exp %h", it.tag, it.a, rdata, it.e);
        end
      end
    end
  end

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] e, input string tag);
    sel = 1'b1; we = 1'b0; addr = a;
    #1;
    q.push_back('{a: a, e: e, tag: tag});
    -> chk_ev;
    @(posedge clk); @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic in1_pulse();
    in1 = 1'b1; @(posedge clk); @(negedge clk);
    in1 = 1'b0; @(posedge clk); @(negedge clk);
  endtask

  task automatic enc_steps(input int n, input logic dir);
    step = 1'b1; up = dir;
    repeat (n) @(posedge clk);
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic restart(input logic [15:0] cfg);
    bus_wr(A_CTRL, 16'd0);
    bus_wr(A_CFG, cfg);
    bus_wr(A_CTRL, 16'd1);
    bus_wr(A_CTRL, 16'd3);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout exp finish");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd_chk(A_CTRL, 16'h0000, "R10 ctrl reset");
    rd_chk(A_CFG,  16'h0000, "R10 cfg reset");
    rd_chk(A_CEIL, 16'hFFFF, "R10 ceiling reset");
    rd_chk(A_CMP,  16'h0000, "R10 compare reset");
    rd_chk(A_STAT, 16'h0000, "R10 status reset");
    rd_chk(A_CNT,  16'h0000, "R10 count reset");

    bus_wr(A_CEIL, 16'd5);
    bus_wr(A_CMP, 16'd7);
    repeat (5) @(negedge clk);
    rd_chk(A_CEIL, 16'hFFFF, "R3 ceiling write while disabled");
    rd_chk(A_CMP,  16'h0000, "R3 compare write while disabled");
    rd_chk(A_STAT, 16'h0000, "R3 no flag while disabled");

    bus_wr(A_CTRL, 16'd3);
    rd_chk(A_CTRL, 16'h0001, "R1 enable+start together not running");
    in1_pulse();
    rd_chk(A_CNT, 16'h0000, "R1 no count before start");
    bus_wr(A_CTRL, 16'd3);
    rd_chk(A_CTRL, 16'h0003, "R1 start after enable runs");

    bus_wr(A_CEIL, 16'd5);
    rd_chk(A_CEIL, 16'hFFFF, "R4 ceiling old value cycle 1");
    rd_chk(A_STAT, 16'h0000, "R4 flag clear cycle 2");
    rd_chk(A_STAT, 16'h0000, "R4 flag clear cycle 3");
    rd_chk(A_STAT, 16'h0001, "R4 ceiling done after 3 cycles");
    rd_chk(A_CEIL, 16'h0005, "R4 ceiling new value");

    bus_wr(A_CFG, 16'd1);
    rd_chk(A_CFG, 16'h0000, "R6 cfg write ignored while enabled");

    repeat (5) in1_pulse();
    rd_chk(A_CNT, 16'd5, "R7 rising edges counted");
    repeat (2) in1_pulse();
    rd_chk(A_CNT, 16'd1, "R9 up wrap at ceiling");
    enc_steps(3, 1'b1);
    rd_chk(A_CNT, 16'd1, "R7 encoder up ignored in event mode");
    enc_steps(2, 1'b0);
    rd_chk(A_CNT, 16'd1, "R7 encoder down ignored in event mode");

    bus_wr(A_CLR, 16'd2);
    rd_chk(A_STAT, 16'h0001, "R5 zero clear bit keeps flag");
    bus_wr(A_CLR, 16'd1);
    rd_chk(A_STAT, 16'h0000, "R5 clear bit drops flag");

    bus_wr(A_CMP, 16'd9);
    repeat (4) @(negedge clk);
    rd_chk(A_STAT, 16'h0002, "R4 compare done flag");
    rd_chk(A_CMP,  16'h0009, "R4 compare new value");

    bus_wr(A_CTRL, 16'd0);
    rd_chk(A_CTRL, 16'h0000, "R2 disabled");
    repeat (2) in1_pulse();
    rd_chk(A_CNT, 16'd1, "R2 count holds while disabled");

    restart(16'd2);
    rd_chk(A_CFG, 16'h0002, "R6 falling edge config");
    in1 = 1'b1; @(posedge clk); @(negedge clk);
    rd_chk(A_CNT, 16'd1, "R6 rising ignored in falling mode");
    in1 = 1'b0; @(posedge clk); @(negedge clk);
    rd_chk(A_CNT, 16'd2, "R6 falling edge counted");

    restart(16'd4);
    in1_pulse();
    rd_chk(A_CNT, 16'd4, "R6 both edges counted");

    restart(16'd1);
    enc_steps(4, 1'b0);
    rd_chk(A_CNT, 16'd0, "R8 encoder down steps");
    enc_steps(1, 1'b0);
    rd_chk(A_CNT, 16'd5, "R9 down wrap to ceiling");
    enc_steps(1, 1'b1);
    rd_chk(A_CNT, 16'd0, "R9 up wrap from ceiling");
    enc_steps(2, 1'b1);
    in1_pulse();
    rd_chk(A_CNT, 16'd2, "R8 encoder up, input 1 ignored");

    done = 1'b1;
    summary();
  end
endmodule